// File: doc/BRIEF.md
# CEC transmit bit waveform generator

This block produces the line waveform for one bit cell at a time on an open-drain, active-low CEC bus. A controller asks for a start bit, a logical 0 or a logical 1 with a one-cycle strobe. The block then asserts a drive-low enable toward the pad. It releases the line after the programmed low time. It keeps the cell busy until the fixed bit period has run out, and then pulses a done flag so that the next bit can be requested.

All timing is counted on a microsecond time base pulse, `us_tick`, that comes from outside the block. A 3-bit trim code moves the release point, which is the rising edge of the line, by a signed offset. The same offset applies to start bits and to data bits. The falling edge always comes at the start of the cell, and the cell period is the same for every trim code. The bit type and the trim code are captured when a request is accepted, so changes on those inputs during a bit do not alter it.

Top module: `cec_bit_tx`

## Requirements
- R1: After synchronous reset, drive_low, busy and bit_done are all 0.
- R2: A request is accepted on a clock edge where req_valid is 1, busy is 0 and req_kind is 00 (start), 01 (logical 0) or 10 (logical 1). In the cycle after that edge, busy and drive_low are both 1.
- R3: With trim code 000, drive_low stays 1 for exactly 3700 us_tick pulses for a start bit, 1500 for a logical 0 and 600 for a logical 1, counted from acceptance.
- R4: Trim codes 001, 010, 011, 100, 101 and 110 shorten the low time by 30, 60, 90, 120, 150 and 180 ticks.
- R5: Trim code 111 lengthens the low time by 30 ticks.
- R6: Start bits receive the same trim offset as data bits.
- R7: busy lasts exactly 4500 ticks for a start bit and 2400 ticks for a data bit, whatever the trim code. bit_done is 1 for exactly one clock, in the first cycle in which busy is 0 again.
- R8: A request made while busy is 1 is ignored, and so is a request with req_kind 11.
- R9: The bit type and the trim code are latched at acceptance. Changing req_kind or trim_sel during a bit has no effect on that bit.
- R10: Cycles without a us_tick pulse do not advance the timing, so busy and drive_low hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-clock pulse per elapsed microsecond |
| req_valid | input | 1 | Bit request strobe |
| req_kind | input | 2 | 00 start, 01 logical 0, 10 logical 1, 11 reserved |
| trim_sel | input | 3 | Release-edge trim code |
| drive_low | output | 1 | 1 pulls the bus line low |
| busy | output | 1 | A bit cell is in progress |
| bit_done | output | 1 | One-clock pulse at the end of the cell |

## Verification
The assertions assume that us_tick is a single-clock pulse, and that a new request arrives only after bit_done has been seen. The timer assertions also assume that rst is applied before any request. The stimulus keeps to these assumptions. It raises req_valid in idle only once per bit. Any strobes or trim changes made during a busy cell are deliberate disturbances. The tick is drawn at random per clock, either every cycle or at a reduced rate. Measured low times and periods are counted in ticks, not clocks, so a sparse tick does not change any expected value.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    localparam int TIME_W = 13;
    localparam int TRIM_W = 3;

    typedef enum logic [1:0] {
        KIND_START = 2'b00,
        KIND_ZERO  = 2'b01,
        KIND_ONE   = 2'b10,
        KIND_RSVD  = 2'b11
    } bit_kind_e;

    typedef struct packed {
        bit_kind_e           kind;
        logic [TRIM_W-1:0]   trim;
        logic [TIME_W-1:0]   low_us;
        logic [TIME_W-1:0]   period_us;
    } cell_cfg_t;

    function automatic logic kind_ok(input logic [1:0] k);
        return k != KIND_RSVD;
    endfunction

    // Signed release-edge offset: code 0 none, 1..6 earlier by step*code, 7 later by step.
    function automatic logic [TIME_W-1:0] trimmed_low(input int nominal, input int step,
                                                      input logic [TRIM_W-1:0] code);
        int v;
        if (code == '0)
            v = nominal;
        else if (code == '1)
            v = nominal + step;
        else
            v = nominal - step * int'(code);
        return TIME_W'(v);
    endfunction

endpackage

// File: rtl/cec_tx_cfg_latch.sv
module cec_tx_cfg_latch
    import cec_tx_pkg::*;
#(
    parameter int START_LOW_US    = 3700,
    parameter int ZERO_LOW_US     = 1500,
    parameter int ONE_LOW_US      = 600,
    parameter int START_PERIOD_US = 4500,
    parameter int DATA_PERIOD_US  = 2400,
    parameter int TRIM_STEP_US    = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [TRIM_W-1:0] trim_sel,
    input  logic              busy,
    output logic              accept,
    output cell_cfg_t         cfg
);

    cell_cfg_t next_cfg;

    assign accept = req_valid && !busy && kind_ok(req_kind);

    always_comb begin
        next_cfg.kind = bit_kind_e'(req_kind);
        next_cfg.trim = trim_sel;
        case (bit_kind_e'(req_kind))
            KIND_START: begin
                next_cfg.low_us    = trimmed_low(START_LOW_US, TRIM_STEP_US, trim_sel);
                next_cfg.period_us = TIME_W'(START_PERIOD_US);
            end
            KIND_ZERO: begin
                next_cfg.low_us    = trimmed_low(ZERO_LOW_US, TRIM_STEP_US, trim_sel);
                next_cfg.period_us = TIME_W'(DATA_PERIOD_US);
            end
            default: begin
                next_cfg.low_us    = trimmed_low(ONE_LOW_US, TRIM_STEP_US, trim_sel);
                next_cfg.period_us = TIME_W'(DATA_PERIOD_US);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.kind      <= KIND_START;
            cfg.trim      <= '0;
            cfg.low_us    <= TIME_W'(START_LOW_US);
            cfg.period_us <= TIME_W'(START_PERIOD_US);
        end else if (accept) begin
            cfg <= next_cfg;
        end
    end

    // R9: the latched cell settings cannot move while a cell runs
    a_r9_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg));

    // R8: the reserved kind is never taken
    a_r8_no_rsvd: assert property (@(posedge clk) disable iff (rst)
        accept |=> cfg.kind != KIND_RSVD);

endmodule

// File: rtl/cec_tx_cell_timer.sv
module cec_tx_cell_timer
    import cec_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              us_tick,
    input  logic [TIME_W-1:0] period_us,
    output logic              busy,
    output logic [TIME_W-1:0] elapsed,
    output logic              bit_done
);

    logic last_tick;

    assign last_tick = (elapsed == period_us - TIME_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            elapsed  <= '0;
            bit_done <= 1'b0;
        end else begin
            bit_done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                elapsed <= '0;
            end else if (busy && us_tick) begin
                if (last_tick) begin
                    busy     <= 1'b0;
                    elapsed  <= '0;
                    bit_done <= 1'b1;
                end else begin
                    elapsed <= elapsed + TIME_W'(1);
                end
            end
        end
    end

    // R7: elapsed time stays within the cell
    a_r7_in_period: assert property (@(posedge clk) disable iff (rst)
        busy |-> elapsed < period_us);

    // R7: done is a single-clock pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        bit_done |=> !bit_done);

    // R10: no tick, no progress
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !us_tick && !accept) |=> (busy && $stable(elapsed)));

endmodule

// File: rtl/cec_tx_line_drive.sv
module cec_tx_line_drive
    import cec_tx_pkg::*;
(
    input  logic              busy,
    input  logic [TIME_W-1:0] elapsed,
    input  logic [TIME_W-1:0] low_us,
    output logic              drive_low
);

    always_comb begin
        drive_low = busy && (elapsed < low_us);
    end

endmodule

// File: rtl/cec_bit_tx.sv
module cec_bit_tx
    import cec_tx_pkg::*;
#(
    parameter int START_LOW_US    = 3700,
    parameter int ZERO_LOW_US     = 1500,
    parameter int ONE_LOW_US      = 600,
    parameter int START_PERIOD_US = 4500,
    parameter int DATA_PERIOD_US  = 2400,
    parameter int TRIM_STEP_US    = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic [2:0] trim_sel,
    output logic       drive_low,
    output logic       busy,
    output logic       bit_done
);

    logic              accept;
    cell_cfg_t         cfg;
    logic [TIME_W-1:0] elapsed;

    cec_tx_cfg_latch #(
        .START_LOW_US    (START_LOW_US),
        .ZERO_LOW_US     (ZERO_LOW_US),
        .ONE_LOW_US      (ONE_LOW_US),
        .START_PERIOD_US (START_PERIOD_US),
        .DATA_PERIOD_US  (DATA_PERIOD_US),
        .TRIM_STEP_US    (TRIM_STEP_US)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .trim_sel  (trim_sel),
        .busy      (busy),
        .accept    (accept),
        .cfg       (cfg)
    );

    cec_tx_cell_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .us_tick   (us_tick),
        .period_us (cfg.period_us),
        .busy      (busy),
        .elapsed   (elapsed),
        .bit_done  (bit_done)
    );

    cec_tx_line_drive u_line (
        .busy      (busy),
        .elapsed   (elapsed),
        .low_us    (cfg.low_us),
        .drive_low (drive_low)
    );

    // R2: a valid request in idle starts a cell that begins low
    a_r2_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_kind != 2'b11) |=> (busy && drive_low));

    // R8: a reserved request in idle leaves the line released
    a_r8_rsvd_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_kind == 2'b11) |=> (!busy && !drive_low));

    // R3: the line is only pulled low inside a cell
    a_r3_low_in_cell: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> busy);

    // R7: end of cell is flagged exactly when busy drops
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> bit_done);

endmodule

// File: tb/sim_cec_bit_tx.sv
module sim_cec_bit_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [2:0] trim_sel = 3'b000;
    logic       drive_low, busy, bit_done;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit ended = 1'b0;

    always #2 clk = ~clk;

    cec_bit_tx u0 (
        .clk       (clk),
        .rst       (rst),
        .us_tick   (us_tick),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .trim_sel  (trim_sel),
        .drive_low (drive_low),
        .busy      (busy),
        .bit_done  (bit_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_low(input int kind, input int code);
        int nom;
        nom = (kind == 0) ? 3700 : (kind == 1) ? 1500 : 600;
        if (code == 0) return nom;
        if (code == 7) return nom + 30;
        return nom - 30 * code;
    endfunction

    function automatic int exp_period(input int kind);
        return (kind == 0) ? 4500 : 2400;
    endfunction

    function automatic string low_tag(input int kind, input int code);
        if (kind == 0) return (code == 0) ? "R3 R6 start low" : "R6 start trim";
        if (code == 0) return "R3 data low";
        if (code == 7) return "R5 late release";
        return "R4 early release";
    endfunction

    // Sends one bit; counts ticks seen while low and while busy.
    task automatic send_bit(input int kind, input int code, input int pct,
                            input bit disturb, input int hold);
        int low_t = 0;
        int per_t = 0;
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        trim_sel  = 3'(code);
        us_tick   = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        check(drive_low == 1'b1, "R2 low after accept", int'(drive_low), 1);
        if (hold > 0) begin
            us_tick = 1'b0;
            repeat (hold) @(negedge clk);
            check(busy && drive_low, "R10 hold without tick", int'(busy && drive_low), 1);
        end
        while (busy && guard < 40000) begin
            us_tick = (($urandom % 100) < pct);
            if (drive_low) low_t += int'(us_tick);
            per_t += int'(us_tick);
            if (disturb) begin
                trim_sel  = 3'($urandom);
                req_kind  = 2'($urandom);
                req_valid = 1'($urandom);
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        us_tick = 1'b0;
        check(guard < 40000, "R7 cell ended", guard, 0);
        check(bit_done == 1'b1, "R7 done when busy drops", int'(bit_done), 1);
        check(low_t == exp_low(kind, code),
              disturb ? "R9 latched low time" : low_tag(kind, code),
              low_t, exp_low(kind, code));
        check(per_t == exp_period(kind), "R7 period", per_t, exp_period(kind));
        @(negedge clk);
        check(bit_done == 1'b0, "R7 done one clock", int'(bit_done), 0);
        check(busy == 1'b0, "R8 no restart from strobe while busy", int'(busy), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000 && !ended) begin
            ended = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check(drive_low == 1'b0, "R1 reset drive_low", int'(drive_low), 0);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(bit_done == 1'b0, "R1 reset bit_done", int'(bit_done), 0);

        // reserved kind must not start a cell (R8)
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'b11;
        us_tick   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        us_tick   = 1'b0;
        @(negedge clk);
        check(!busy && !drive_low, "R8 reserved kind ignored", int'(busy || drive_low), 0);

        for (int k = 0; k < 3; k++)
            for (int c = 0; c < 8; c++)
                send_bit(k, c, 100, 1'b0, 0);

        send_bit(1, 3, 100, 1'b0, 40);

        for (int i = 0; i < 8; i++)
            send_bit(int'($urandom % 3), int'($urandom % 8), 60 + int'($urandom % 40), 1'b1, 0);

        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule